// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Router

This block collects interrupt pin changes from devices on a PCI bus and turns them into levels on the inputs of a legacy interrupt controller. Each change arrives as a single transfer carrying the device/function number, the pin index (0 to 3) and the new level. The slot number is taken from the device/function number. A rotating swizzle maps the pin to one of four shared PCI interrupt lines. The new level is then stored for that line.

A four-entry routing table, one 8-bit entry per line, is written and read through a plain register port. It names the controller input that each line drives. Each controller input is driven high while at least one line routed to it is high. A line can therefore be lowered by one device while another line on the same input stays high, and the input does not drop. Outputs are registered, so they change only on clock edges and never glitch.

The source port is valid/ready. `src_ready` is low during reset and in the first cycle after reset. From then on it stays high, because the block can take one pin change in every cycle. A transfer happens on a rising edge where `src_valid` and `src_ready` are both high. A source may hold `src_valid` for as long as it likes while `src_ready` is low, and nothing is taken in that time.

Top module: `pci_irq_router`

## Requirements
- R1: After reset all controller outputs are low, all four line levels are low, and every routing entry reads back as 0x80.
- R2: The slot is `src_devfn[7:3]`. For slots 18, 19, 20 and 21, pin p maps to line `((slot - 18) + p) mod 4`.
- R3: For any other slot, the line number equals the pin index.
- R4: An accepted transfer stores `src_level` as the level of its mapped line. The stored level is held until a later transfer maps to the same line.
- R5: A write with `cfg_we` high stores `cfg_wdata` in the entry that `cfg_idx` selects. `cfg_idx` value n selects line n. `cfg_rdata` returns the entry that `cfg_idx` selects, combinationally.
- R6: A line whose entry has bit 7 set drives no output, whatever the value of the low bits.
- R7: Output k is high exactly when at least one line is high and has an entry equal to k. Several lines that share one output are ORed together.
- R8: A line level change or a table write takes effect on `irq_out` at the rising edge after the edge that stored it, and not before.
- R9: `src_ready` is low while `rst_n` is low. It is high from the second rising edge after reset onward. A cycle with `src_valid` low changes no line.
- R10: An entry with bit 7 clear whose value is 16 or more drives no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 1 | A pin change is offered |
| src_ready | output | 1 | The block accepts pin changes |
| src_devfn | input | 8 | Device/function number of the source |
| src_pin | input | 2 | Interrupt pin index of the source, 0 to 3 |
| src_level | input | 1 | New level of that pin |
| cfg_we | input | 1 | Routing entry write strobe |
| cfg_idx | input | 2 | Routing entry (line) index for read and write |
| cfg_wdata | input | 8 | Routing entry write value |
| cfg_rdata | output | 8 | Routing entry selected by `cfg_idx` |
| irq_out | output | 16 | Interrupt controller input levels |

## Verification
The bench drives slots on both edges of the swizzle window (17, 18, 20, 21) and slots well outside it. A design that rotated outside the window, or that failed to wrap the modulo, would raise the wrong output bit. Two lines are routed to one output and then lowered one at a time. A router that copied the last line written instead of ORing the lines would drop that output too early. Entries with bit 7 set over matching low bits, and entries of 16 or more with bit 7 clear, must drive nothing. The exact edge on which a table write or a pin change appears is checked, together with held levels and cycles where `src_valid` is low, against a reference model on every clock.

// File: rtl/pci_irq_pkg.sv
package pci_irq_pkg;
  localparam int ENTRY_W     = 8;
  localparam int OFF_BIT     = ENTRY_W - 1;
  localparam logic [ENTRY_W-1:0] ENTRY_RESET = 8'h80;
  typedef logic [ENTRY_W-1:0] route_entry_t;
endpackage

// File: rtl/pci_irq_swizzle.sv
module pci_irq_swizzle #(
  parameter int DEVFN_W    = 8,
  parameter int LINE_W     = 2,
  parameter int FIRST_SLOT = 18
) (
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [LINE_W-1:0]  pin,
  output logic [LINE_W-1:0]  line
);
  localparam int SLOT_W = DEVFN_W - 3;
  localparam int NLINES = 1 << LINE_W;
  localparam logic [SLOT_W-1:0] LO_SLOT = SLOT_W'(FIRST_SLOT);
  localparam logic [SLOT_W-1:0] HI_SLOT = SLOT_W'(FIRST_SLOT + NLINES - 1);

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] rel;
  logic              in_window;

  always_comb begin
    slot      = devfn[DEVFN_W-1:3];
    rel       = slot - LO_SLOT;
    in_window = (slot >= LO_SLOT) && (slot <= HI_SLOT);
    line      = in_window ? (rel[LINE_W-1:0] + pin) : pin;
  end
endmodule

// File: rtl/pci_irq_line_state.sv
module pci_irq_line_state #(
  parameter int LINES  = 4,
  parameter int LINE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [LINE_W-1:0] upd_line,
  input  logic              upd_level,
  output logic [LINES-1:0]  level
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     level[l] <= 1'b0;
      else if (upd && (upd_line == LINE_W'(l)))       level[l] <= upd_level;
    end
  end
endmodule

// File: rtl/pci_irq_route_table.sv
module pci_irq_route_table
  import pci_irq_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int LINE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LINE_W-1:0] idx,
  input  route_entry_t      wdata,
  output route_entry_t      rdata,
  output route_entry_t      entry [LINES]
);
  for (genvar l = 0; l < LINES; l++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                entry[l] <= ENTRY_RESET;
      else if (we && (idx == LINE_W'(l)))        entry[l] <= wdata;
    end
  end

  assign rdata = entry[idx];
endmodule

// File: rtl/pci_irq_fanin.sv
module pci_irq_fanin
  import pci_irq_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int INPUTS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES-1:0]   level,
  input  route_entry_t       entry [LINES],
  output logic [INPUTS-1:0]  irq
);
  logic [INPUTS-1:0] irq_d;

  for (genvar k = 0; k < INPUTS; k++) begin : g_in
    logic [LINES-1:0] hit;
    for (genvar l = 0; l < LINES; l++) begin : g_ln
      assign hit[l] = level[l] && !entry[l][OFF_BIT] &&
                      (entry[l] == ENTRY_W'(k));
    end
    assign irq_d[k] = |hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= '0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pci_irq_pkg::*;
#(
  parameter int DEVFN_W    = 8,
  parameter int LINES      = 4,
  parameter int INPUTS     = 16,
  parameter int FIRST_SLOT = 18
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       src_valid,
  output logic                       src_ready,
  input  logic [DEVFN_W-1:0]         src_devfn,
  input  logic [$clog2(LINES)-1:0]   src_pin,
  input  logic                       src_level,
  input  logic                       cfg_we,
  input  logic [$clog2(LINES)-1:0]   cfg_idx,
  input  logic [ENTRY_W-1:0]         cfg_wdata,
  output logic [ENTRY_W-1:0]         cfg_rdata,
  output logic [INPUTS-1:0]          irq_out
);
  localparam int LINE_W = $clog2(LINES);

  logic              ready_q;
  logic              take;
  logic [LINE_W-1:0] mapped;
  logic [LINES-1:0]  line_q;
  route_entry_t      table_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign src_ready = ready_q;
  assign take      = src_valid && ready_q;

  pci_irq_swizzle #(
    .DEVFN_W(DEVFN_W), .LINE_W(LINE_W), .FIRST_SLOT(FIRST_SLOT)
  ) u_swz (
    .devfn(src_devfn), .pin(src_pin), .line(mapped)
  );

  pci_irq_line_state #(.LINES(LINES), .LINE_W(LINE_W)) u_lines (
    .clk(clk), .rst_n(rst_n), .upd(take), .upd_line(mapped),
    .upd_level(src_level), .level(line_q)
  );

  pci_irq_route_table #(.LINES(LINES), .LINE_W(LINE_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .entry(table_q)
  );

  pci_irq_fanin #(.LINES(LINES), .INPUTS(INPUTS)) u_fan (
    .clk(clk), .rst_n(rst_n), .level(line_q), .entry(table_q), .irq(irq_out)
  );
endmodule

// File: rtl/pci_irq_router_chk.sv
module pci_irq_router_chk #(
  parameter int LINES  = 4,
  parameter int INPUTS = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     src_valid,
  input logic                     src_ready,
  input logic                     cfg_we,
  input logic [$clog2(LINES)-1:0] cfg_idx,
  input logic [7:0]               cfg_rdata,
  input logic [LINES-1:0]         line_lvl,
  input logic [INPUTS-1:0]        irq_out
);
  // R9: ready once reset has been released for a full cycle
  assert_ready_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> src_ready);

  // R4 / R9: with no transfer the stored line levels do not move
  assert_line_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_valid && src_ready) |=> $stable(line_lvl));

  // R5: no write and same index keeps the readback value
  assert_table_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> (!$stable(cfg_idx) || $stable(cfg_rdata)));

  // R7: all lines low gives all outputs low one edge later
  assert_quiet_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_lvl == '0) |=> (irq_out == '0));

  // R7: each line drives at most one output
  assert_fanout_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($countones(irq_out) <= $countones($past(line_lvl))));
endmodule

bind pci_irq_router pci_irq_router_chk #(.LINES(LINES), .INPUTS(INPUTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
  .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_rdata(cfg_rdata),
  .line_lvl(line_q), .irq_out(irq_out)
);

// File: tb/pci_irq_router_tb.sv
`timescale 1ns/1ps
module pci_irq_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic [7:0]  src_devfn = '0;
  logic [1:0]  src_pin = '0;
  logic        src_level = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] irq_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pci_irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
    .src_devfn(src_devfn), .src_pin(src_pin), .src_level(src_level),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_out(irq_out)
  );

  // behavioural reference model
  int m_line [4] = '{0, 0, 0, 0};
  int m_tab  [4] = '{128, 128, 128, 128};
  int m_out  = 0;
  bit m_rdy  = 0;

  function automatic int ref_route();
    int r = 0;
    for (int l = 0; l < 4; l++)
      if (m_line[l] != 0 && m_tab[l] < 16) r = r | (1 << m_tab[l]);
    return r;
  endfunction

  function automatic int ref_line(int devfn, int pin);
    int slot = devfn / 8;
    if (slot >= 18 && slot <= 21) return (slot - 18 + pin) % 4;
    return pin;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < 4; l++) begin m_line[l] = 0; m_tab[l] = 128; end
      m_out = 0; m_rdy = 0;
    end else begin
      int nxt;
      nxt = ref_route();
      if (src_valid && m_rdy) m_line[ref_line(src_devfn, src_pin)] = src_level;
      if (cfg_we) m_tab[cfg_idx] = cfg_wdata;
      m_rdy = 1;
      m_out = nxt;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model (R7, R8, R9)
  always @(negedge clk) if (rst_n && !done) begin
    check("R7/R8 model irq_out", irq_out, m_out);
    check("R9 model src_ready", src_ready, m_rdy);
  end

  task automatic send(int devfn, int pin, int lvl);
    @(negedge clk);
    src_valid = 1; src_devfn = devfn[7:0]; src_pin = pin[1:0]; src_level = lvl[0];
    @(negedge clk);
    src_valid = 0;
  endtask

  task automatic cfg_wr(int idx, int val);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx[1:0]; cfg_wdata = val[7:0];
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_rd(int idx, int exp, string tag);
    @(negedge clk);
    cfg_idx = idx[1:0];
    #1 check(tag, cfg_rdata, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 ready low in reset", src_ready, 0);
    check("R1 outputs low in reset", irq_out, 0);
    rst_n = 1;
    for (int i = 0; i < 4; i++) cfg_rd(i, 8'h80, "R1 entry reset");

    send(144, 0, 1);                       // slot 18 pin 0 -> line 0
    @(negedge clk);
    check("R6 disabled line silent", irq_out, 0);

    cfg_wr(0, 3);
    check("R8 not yet visible", irq_out, 0);
    @(negedge clk);
    check("R8 visible next edge", irq_out, 16'h0008);
    cfg_rd(0, 3, "R5 readback");
    cfg_wr(1, 4); cfg_wr(2, 6); cfg_wr(3, 7);
    cfg_rd(2, 6, "R5 readback idx2");
    send(144, 0, 0); @(negedge clk);
    check("R4 line lowered", irq_out, 0);

    send(160, 3, 1);                       // slot 20 pin 3 -> line 1
    check("R8 pin change latency", irq_out, 0);
    @(negedge clk);
    check("R2 slot20 pin3", irq_out, 16'h0010);
    send(160, 3, 0);
    send(169, 1, 1); @(negedge clk);       // slot 21 pin 1 -> line 0 (wrap)
    check("R2 slot21 wrap", irq_out, 16'h0008);
    send(169, 1, 0);
    send(40, 2, 1); @(negedge clk);        // slot 5 -> line 2
    check("R3 slot5 passthrough", irq_out, 16'h0040);
    send(40, 2, 0);
    send(255, 3, 1); @(negedge clk);       // slot 31 -> line 3
    check("R3 slot31 passthrough", irq_out, 16'h0080);
    send(255, 3, 0);
    send(136, 1, 1); @(negedge clk);       // slot 17 -> line 1
    check("R3 slot17 passthrough", irq_out, 16'h0010);
    send(136, 1, 0);

    cfg_wr(1, 9); cfg_wr(2, 9);
    send(160, 3, 1); send(40, 2, 1); @(negedge clk);
    check("R7 two lines shared", irq_out, 16'h0200);
    send(160, 3, 0); @(negedge clk);
    check("R7 shared input held", irq_out, 16'h0200);
    send(40, 2, 0); @(negedge clk);
    check("R7 shared input released", irq_out, 0);

    send(40, 2, 1);
    repeat (5) @(negedge clk);
    check("R4 level held", irq_out, 16'h0200);
    @(negedge clk);
    src_devfn = 40; src_pin = 2; src_level = 0; src_valid = 0;
    repeat (3) @(negedge clk);
    check("R9 no valid no change", irq_out, 16'h0200);
    send(40, 2, 0);

    cfg_wr(3, 8'h20);
    send(255, 3, 1); @(negedge clk);
    check("R10 entry out of range", irq_out, 0);
    cfg_wr(3, 8'h0F); @(negedge clk);
    check("R5 entry 15", irq_out, 16'h8000);
    cfg_wr(3, 8'h8F); @(negedge clk);
    check("R6 bit7 over match", irq_out, 0);
    cfg_rd(3, 8'h8F, "R5 readback disabled");
    send(255, 3, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule